// File: doc/BRIEF.md
# Serial Identifier CRC-8 Checker

This block validates a 64-bit device identifier that a single-wire bus receiver delivers one recovered bit at a time. A start pulse opens a new identifier. The block then runs a CRC-8 over the first 56 bits. It collects the last 8 bits as the stored check byte. After the sixty-fourth bit it compares the two values. Bus timing, presence detection and command decoding are handled elsewhere.

Bits arrive least significant bit first. The register is kept in reflected form: its initial value is zero and its feedback constant is 0x8C, which is the generator x^8 + x^5 + x^4 + 1 bit-reversed. The stored byte is in true form, so the comparison applies no inversion. A caller reads the running CRC at any time. It waits for the single-cycle done strobe and then samples the match flag, which holds its value until the next start.

Top module: `id_crc8_checker`

## Requirements
- R1: While synchronous reset `rst` is high, and in the first cycle after it, `crc_o` is 0x00 and `done_o` and `match_o` are low.
- R2: A `start_i` pulse sets `crc_o` to 0x00, clears the bit count and drops `done_o` and `match_o` in the next cycle. A bit offered with `bit_valid_i` in the same cycle as `start_i` is not taken.
- R3: Each bit accepted among the first 56 of an identifier updates `crc_o` in the next cycle. The update is next = (crc >> 1) XOR (0x8C if crc[0] XOR bit else 0x00). A cycle with `bit_valid_i` low leaves all outputs unchanged.
- R4: Accepted bits 57 to 64 leave `crc_o` unchanged.
- R5: `done_o` is high for exactly one cycle: the cycle after the 64th accepted bit.
- R6: From the cycle after the 64th bit until the next start or reset, `match_o` is high exactly when `crc_o` equals the byte built from bits 57 to 64, where bit 57 is the byte's bit 0. Before that point `match_o` is low.
- R7: Bits offered after the 64th and before the next start are ignored. `crc_o` and `match_o` keep their values, and `done_o` does not pulse again.
- R8: The 56 bits of bytes 0x02, 0x1C, 0xB8, 0x01, 0x00, 0x00, 0x00, each sent least significant bit first, give `crc_o` = 0xA2. The identifier that ends in check byte 0xA2 gives a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a new identifier |
| bit_valid_i | input | 1 | Qualifies bit_data_i for one cycle |
| bit_data_i | input | 1 | Recovered identifier bit, LSB first |
| crc_o | output | 8 | Running CRC over the body bits |
| done_o | output | 1 | One-cycle strobe after bit 64 |
| match_o | output | 1 | Check byte agreed with computed CRC |

## Verification
The embedded assertions check several properties on every cycle:
- the single-cycle shape of the done strobe;
- the clearing effect of start;
- that the CRC register holds when no bit is taken or when bits fall in the check byte;
- that nothing moves once the identifier is complete.

Whether the CRC arithmetic is right, and whether the match decision is right, can be shown only by the bench's scenarios. Those scenarios compare every output each cycle with a behavioural model. They include the known identifier, random identifiers with good and corrupted check bytes, idle gaps, surplus bits, and restarts in mid-frame.

// File: rtl/id_crc8_pkg.sv
package id_crc8_pkg;

    localparam int ID_BITS  = 64;
    localparam int CRC_W    = 8;
    localparam logic [CRC_W-1:0] FEEDBACK = 8'h8C;

    typedef enum logic [1:0] {
        PH_BODY  = 2'd0,
        PH_CHECK = 2'd1,
        PH_FULL  = 2'd2
    } phase_e;

    typedef struct packed {
        logic accept;
        logic last;
        logic din;
        phase_e phase;
    } bit_evt_t;

    function automatic logic [CRC_W-1:0] crc_step(
        input logic [CRC_W-1:0] cur,
        input logic             din,
        input logic [CRC_W-1:0] fb
    );
        logic [CRC_W-1:0] shifted;
        shifted = cur >> 1;
        return (cur[0] ^ din) ? (shifted ^ fb) : shifted;
    endfunction

endpackage

// File: rtl/id_bit_counter.sv
module id_bit_counter
    import id_crc8_pkg::*;
#(
    parameter int TOTAL = ID_BITS,
    parameter int CHK   = CRC_W
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     bit_valid_i,
    input  logic     bit_data_i,
    output bit_evt_t evt_o
);
    localparam int BODY = TOTAL - CHK;
    localparam int CW   = $clog2(TOTAL + 1);

    logic [CW-1:0] cnt;
    phase_e        ph;

    always_comb begin
        if (cnt < CW'(BODY))       ph = PH_BODY;
        else if (cnt < CW'(TOTAL)) ph = PH_CHECK;
        else                       ph = PH_FULL;
    end

    assign evt_o.phase  = ph;
    assign evt_o.din    = bit_data_i;
    assign evt_o.accept = bit_valid_i && !start_i && (ph != PH_FULL);
    assign evt_o.last   = evt_o.accept && (cnt == CW'(TOTAL - 1));

    always_ff @(posedge clk) begin
        if (rst || start_i) cnt <= '0;
        else if (evt_o.accept) cnt <= cnt + 1'b1;
    end

    // R7
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_FULL && !start_i) |=> (cnt == CW'(TOTAL)));

endmodule

// File: rtl/id_crc_engine.sv
module id_crc_engine
    import id_crc8_pkg::*;
#(
    parameter int               W  = CRC_W,
    parameter logic [W-1:0]     FB = FEEDBACK
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  bit_evt_t     evt_i,
    output logic [W-1:0] crc_o
);
    logic [W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || start_i) crc_q <= '0;
        else if (evt_i.accept && evt_i.phase == PH_BODY)
            crc_q <= crc_step(crc_q, evt_i.din, FB);
    end

    assign crc_o = crc_q;

    // R3
    crc_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!evt_i.accept && !start_i) |=> $stable(crc_q));

    // R4
    crc_check_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_i.accept && evt_i.phase == PH_CHECK && !start_i) |=> $stable(crc_q));

endmodule

// File: rtl/id_check_compare.sv
module id_check_compare
    import id_crc8_pkg::*;
#(
    parameter int W = CRC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  bit_evt_t     evt_i,
    input  logic [W-1:0] crc_i,
    output logic         done_o,
    output logic         match_o
);
    logic [W-1:0] rx_q;
    logic [W-1:0] rx_full;

    assign rx_full = {evt_i.din, rx_q[W-1:1]};

    always_ff @(posedge clk) begin
        if (rst || start_i) begin
            rx_q    <= '0;
            done_o  <= 1'b0;
            match_o <= 1'b0;
        end else begin
            done_o <= evt_i.last;
            if (evt_i.accept && evt_i.phase == PH_CHECK) rx_q <= rx_full;
            if (evt_i.last) match_o <= (rx_full == crc_i);
        end
    end

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6
    match_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(match_o) |-> done_o);

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!done_o && !match_o));

endmodule

// File: rtl/id_crc8_checker.sv
module id_crc8_checker
    import id_crc8_pkg::*;
#(
    parameter int TOTAL = ID_BITS,
    parameter int W     = CRC_W,
    parameter logic [W-1:0] FB = FEEDBACK
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         bit_valid_i,
    input  logic         bit_data_i,
    output logic [W-1:0] crc_o,
    output logic         done_o,
    output logic         match_o
);
    bit_evt_t evt;

    id_bit_counter #(.TOTAL(TOTAL), .CHK(W)) u_cnt (
        .clk(clk), .rst(rst), .start_i(start_i),
        .bit_valid_i(bit_valid_i), .bit_data_i(bit_data_i), .evt_o(evt)
    );

    id_crc_engine #(.W(W), .FB(FB)) u_crc (
        .clk(clk), .rst(rst), .start_i(start_i), .evt_i(evt), .crc_o(crc_o)
    );

    id_check_compare #(.W(W)) u_cmp (
        .clk(clk), .rst(rst), .start_i(start_i), .evt_i(evt),
        .crc_i(crc_o), .done_o(done_o), .match_o(match_o)
    );

    // R7
    full_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.phase == PH_FULL && !start_i) |=> ($stable(crc_o) && $stable(match_o) && !done_o));

    // R2
    start_zero_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (crc_o == '0));

endmodule

// File: tb/id_crc8_checker_bench.sv
module id_crc8_checker_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       bit_valid_i = 1'b0;
    logic       bit_data_i = 1'b0;
    logic [7:0] crc_o;
    logic       done_o;
    logic       match_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    id_crc8_checker u_id_crc8_checker (
        .clk(clk), .rst(rst), .start_i(start_i), .bit_valid_i(bit_valid_i),
        .bit_data_i(bit_data_i), .crc_o(crc_o), .done_o(done_o), .match_o(match_o)
    );

    // behavioural reference
    bit m_bits[$];
    bit m_done = 0;
    bit m_match = 0;

    function automatic logic [7:0] ref_crc(input int n);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < n && i < m_bits.size(); i++) begin
            bit fb = c[0] ^ m_bits[i];
            c = c >> 1;
            if (fb) c = c ^ 8'h8C;
        end
        return c;
    endfunction

    function automatic logic [7:0] ref_rx();
        logic [7:0] b = 8'h00;
        for (int i = 0; i < 8; i++) b[i] = m_bits[56 + i];
        return b;
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst || start_i) begin
            m_bits.delete();
            m_done <= 0;
            m_match <= 0;
        end else begin
            m_done <= 0;
            if (bit_valid_i && m_bits.size() < 64) begin
                m_bits.push_back(bit_data_i);
                if (m_bits.size() == 64) begin
                    m_done <= 1;
                    m_match <= (ref_crc(56) == ref_rx());
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // per-cycle comparison against the model (R3, R4, R5, R6, R7)
    always @(negedge clk) begin
        if (!rst) begin
            check("R3/R4 crc_o", {24'h0, crc_o}, {24'h0, ref_crc(56)});
            check("R5 done_o", {31'h0, done_o}, {31'h0, m_done});
            check("R6 match_o", {31'h0, match_o}, {31'h0, m_match});
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_valid_i = 0;
            start_i = 0;
        end
    endtask

    task automatic do_start();
        @(negedge clk);
        start_i = 1;
        bit_valid_i = 0;
        @(negedge clk);
        start_i = 0;
    endtask

    task automatic send_bits(input logic [63:0] id, input int from, input int upto, input int gap);
        for (int i = from; i < upto; i++) begin
            @(negedge clk);
            start_i = 0;
            bit_valid_i = 1;
            bit_data_i = id[i];
            if (gap > 0) begin
                @(negedge clk);
                bit_valid_i = 0;
                bit_data_i = ~bit_data_i;
                for (int g = 1; g < gap; g++) @(negedge clk);
            end
        end
        @(negedge clk);
        bit_valid_i = 0;
    endtask

    function automatic logic [7:0] crc56(input logic [63:0] id);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < 56; i++) begin
            bit fb = c[0] ^ id[i];
            c = c >> 1;
            if (fb) c = c ^ 8'h8C;
        end
        return c;
    endfunction

    logic [63:0] known = 64'hA200_0000_01B8_1C02;

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state, checked during reset
        check("R1 crc_o in reset", {24'h0, crc_o}, 32'h0);
        check("R1 done_o in reset", {31'h0, done_o}, 32'h0);
        check("R1 match_o in reset", {31'h0, match_o}, 32'h0);
        rst = 0;
        @(negedge clk);
        check("R1 crc_o after reset", {24'h0, crc_o}, 32'h0);

        // R8 known identifier
        do_start();
        send_bits(known, 0, 56, 0);
        check("R8 crc of known body", {24'h0, crc_o}, 32'hA2);
        send_bits(known, 56, 64, 0);
        check("R8 known identifier matches", {31'h0, match_o}, 32'h1);

        // R7 surplus bits after 64 are ignored
        send_bits(~known, 0, 16, 0);
        check("R7 crc_o held", {24'h0, crc_o}, 32'hA2);
        check("R7 match_o held", {31'h0, match_o}, 32'h1);

        // R2 start clears, bit with start not taken
        @(negedge clk);
        start_i = 1;
        bit_valid_i = 1;
        bit_data_i = 1;
        @(negedge clk);
        start_i = 0;
        bit_valid_i = 0;
        check("R2 crc cleared", {24'h0, crc_o}, 32'h0);
        check("R2 match cleared", {31'h0, match_o}, 32'h0);
        send_bits(64'h1, 0, 1, 0);
        check("R2 bit with start dropped", {24'h0, crc_o}, 32'h8C);

        // random good and bad identifiers, with gaps (R3, R5, R6)
        for (int t = 0; t < 12; t++) begin
            logic [63:0] id;
            id = {$urandom, $urandom};
            id[63:56] = crc56(id);
            if (t % 3 == 1) id[63:56] = id[63:56] ^ 8'h10;
            do_start();
            send_bits(id, 0, 64, t % 3);
            idle(2);
            check("R6 match decision", {31'h0, match_o}, {31'h0, (t % 3 != 1)});
        end

        // restart mid-frame (R2)
        do_start();
        send_bits(known, 0, 30, 0);
        do_start();
        send_bits(known, 0, 64, 1);
        idle(1);
        check("R2 restart then known matches", {31'h0, match_o}, 32'h1);

        // reset mid-frame (R1)
        send_bits(known, 0, 10, 0);
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 crc after mid reset", {24'h0, crc_o}, 32'h0);

        idle(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule